// File: doc/BRIEF.md
# Byte-Wide Write-Once Memory Device Model

This block is a synthesizable stand-in for a byte-wide memory whose cells can only be cleared electrically and restored by a bulk erase. A device programmer under test talks to it over its normal pins. The pins are an active-low chip select, an active-low output enable, an address and a data bus. Three digital flags stand in for the analog levels. One marks that the output-enable pin is held at programming voltage. One marks that address line 9 is held at identification voltage. One marks that the supply is raised to its programming level. The data bus is split into `data_in`, `data_out` and `data_oe` so that the model stays synthesizable.

Every cycle a mode decoder sorts the pins into one of eight modes: STANDBY, OUT_OFF, READ, VERIFY, ID_READ, PROGRAM, INHIBIT and BUSY. A registered output stage drives the addressed byte or an identification code in READ, VERIFY and ID_READ. In every other mode the bus is released. A pulse state machine measures each low pulse on the chip select while programming conditions hold. It has five states: P_IDLE, P_ARMED, P_PULSE, P_WRITE and P_BLOCKED. Its transitions are:
- enter_prog: P_IDLE to P_ARMED.
- dc_low: P_IDLE to P_BLOCKED.
- fall: P_ARMED to P_PULSE.
- accept: P_PULSE to P_WRITE.
- short: P_PULSE to P_ARMED.
- overlong: P_PULSE to P_BLOCKED.
- commit: P_WRITE to P_ARMED.
- release: P_BLOCKED to P_ARMED.
- abort: back to P_IDLE whenever the conditions drop.

Only a pulse whose width falls inside the window is committed, and it is committed as a bitwise AND. An erase sequencer has two states, E_IDLE and E_SWEEP. Its start transition is taken on a request, and its done transition is taken after the last byte. The sweep writes 0xFF through the whole array and holds a busy flag while it runs. The sequencer leaves reset in E_SWEEP, so the array starts fully erased.

Top module: `eprom_model`

## Requirements
- R1: During reset and for exactly 2**ARR_AW cycles after its release, `erase_busy` is high and `data_oe` is low. Afterwards every byte reads 0xFF.
- R2: When `ce_n`=0, `oe_n`=0, `vpp_hv`=0, `id_hv`=0 and the sequencer is not busy, on the next cycle `data_oe`=1 and `data_out` carries the byte at the low ARR_AW bits of `addr`. The upper address bits are ignored.
- R3: When `ce_n`=1 and `vpp_hv`=0, `data_oe` is 0 on the next cycle, whatever the level of `oe_n`.
- R4: When `ce_n`=0, `oe_n`=1 and `vpp_hv`=0, `data_oe` is 0 on the next cycle.
- R5: Suppose `vpp_hv`=1 and `vcc_prog`=1, and `ce_n` has been seen high in that state. A low pulse on `ce_n` lasting n sampled cycles, with PW_MIN ≤ n ≤ PW_MAX, latches `addr` and `data_in` on its first low cycle. The byte is written one cycle after `ce_n` is next seen high.
- R6: A committed write stores the old byte AND `data_in`. Bits can only be cleared.
- R7: A pulse shorter than PW_MIN or longer than PW_MAX changes nothing. A `ce_n` that is already low when programming conditions start never writes, until it has returned high and a fresh pulse follows.
- R8: While `vpp_hv`=1, `data_oe` is 0. With `ce_n` held high (inhibit) or with `vcc_prog`=0, nothing is written.
- R9: With `vcc_prog`=1 and `vpp_hv`=0, a read (verify) returns stored data as in R2.
- R10: With `id_hv`=1 and read conditions met, `data_out` is 0x8F when `addr[0]`=0 and 0x85 when `addr[0]`=1.
- R11: When `erase_req`=1 while not busy, `erase_busy` rises on the next cycle and stays high for 2**ARR_AW cycles. During that time `data_oe` is 0 and pulses are ignored. Afterwards every byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address; bit 0 also selects the identification byte |
| ce_n | input | 1 | Active-low chip select and program strobe |
| oe_n | input | 1 | Active-low output enable |
| vpp_hv | input | 1 | Output-enable pin held at programming voltage |
| vcc_prog | input | 1 | Supply raised to programming level |
| id_hv | input | 1 | Address line 9 held at identification voltage |
| data_in | input | 8 | Data presented by the programmer |
| erase_req | input | 1 | Start a bulk erase |
| data_out | output | 8 | Byte driven by the model |
| data_oe | output | 1 | Model drives the bus |
| erase_busy | output | 1 | Erase sweep in progress |

## Verification
The properties assume that the control pins change only between clock edges. They also assume that the programmer holds `addr` and `data_in` steady from the falling strobe onward, and that reset is applied once at the start. The stimulus keeps to this. It drives every input on the falling clock edge. It raises and drops the programming flags only while `ce_n` is high, except in the one case that deliberately starts with the strobe already low. It keeps at least two idle cycles between pulses, so the commit cycle never coincides with a new falling strobe.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

    localparam logic [7:0] MFG_ID = 8'h8F;
    localparam logic [7:0] DEV_ID = 8'h85;
    localparam logic [7:0] BLANK  = 8'hFF;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_OUT_OFF,
        MD_READ,
        MD_VERIFY,
        MD_ID_READ,
        MD_PROGRAM,
        MD_INHIBIT,
        MD_BUSY
    } mode_e;

    typedef enum logic [2:0] {
        P_IDLE,
        P_ARMED,
        P_PULSE,
        P_WRITE,
        P_BLOCKED
    } pulse_st_e;

    typedef enum logic {
        E_IDLE,
        E_SWEEP
    } erase_st_e;

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
    import eprom_pkg::*;
(
    input  logic ce_n,
    input  logic oe_n,
    input  logic vpp_hv,
    input  logic vcc_prog,
    input  logic id_hv,
    input  logic busy,
    output logic drive,
    output logic id_sel,
    output logic prog_ok
);

    mode_e mode;

    always_comb begin
        if (busy)
            mode = MD_BUSY;
        else if (vpp_hv)
            mode = ce_n ? MD_INHIBIT : MD_PROGRAM;
        else if (ce_n)
            mode = MD_STANDBY;
        else if (oe_n)
            mode = MD_OUT_OFF;
        else if (id_hv)
            mode = MD_ID_READ;
        else if (vcc_prog)
            mode = MD_VERIFY;
        else
            mode = MD_READ;
    end

    always_comb begin
        unique case (mode)
            MD_READ, MD_VERIFY: begin
                drive  = 1'b1;
                id_sel = 1'b0;
            end
            MD_ID_READ: begin
                drive  = 1'b1;
                id_sel = 1'b1;
            end
            default: begin
                drive  = 1'b0;
                id_sel = 1'b0;
            end
        endcase
    end

    assign prog_ok = vpp_hv & vcc_prog & ~busy;

endmodule

// File: rtl/eprom_pulse_fsm.sv
module eprom_pulse_fsm
    import eprom_pkg::*;
#(
    parameter int AW     = 6,
    parameter int PW_MIN = 95,
    parameter int PW_MAX = 105
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_ok,
    input  logic          ce_n,
    input  logic [AW-1:0] addr_in,
    input  logic [7:0]    data_in,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);

    localparam int CW = $clog2(PW_MAX + 1);
    localparam logic [CW-1:0] MIN_C = CW'(PW_MIN);
    localparam logic [CW-1:0] MAX_C = CW'(PW_MAX);
    localparam logic [CW-1:0] ONE_C = CW'(1);

    pulse_st_e state, state_nx;
    logic [CW-1:0] width_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    data_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= P_IDLE;
        else
            state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            P_IDLE: begin
                if (prog_ok)
                    state_nx = ce_n ? P_ARMED : P_BLOCKED;     // enter_prog / dc_low
            end
            P_ARMED: begin
                if (!prog_ok)
                    state_nx = P_IDLE;                         // abort
                else if (!ce_n)
                    state_nx = P_PULSE;                        // fall
            end
            P_PULSE: begin
                if (!prog_ok)
                    state_nx = P_IDLE;                         // abort
                else if (!ce_n) begin
                    if (width_q >= MAX_C)
                        state_nx = P_BLOCKED;                  // overlong
                end else if (width_q >= MIN_C)
                    state_nx = P_WRITE;                        // accept
                else
                    state_nx = P_ARMED;                        // short
            end
            P_WRITE: begin
                state_nx = P_ARMED;                            // commit
            end
            P_BLOCKED: begin
                if (!prog_ok)
                    state_nx = P_IDLE;                         // abort
                else if (ce_n)
                    state_nx = P_ARMED;                        // release
            end
            default: state_nx = P_IDLE;
        endcase
    end

    // width counter and capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_q <= '0;
            addr_q  <= '0;
            data_q  <= '0;
        end else if (state == P_ARMED && state_nx == P_PULSE) begin
            width_q <= ONE_C;
            addr_q  <= addr_in;
            data_q  <= data_in;
        end else if (state == P_PULSE && !ce_n && width_q < MAX_C) begin
            width_q <= width_q + ONE_C;
        end
    end

    // outputs
    always_comb begin
        wr_en   = (state == P_WRITE);
        wr_addr = addr_q;
        wr_data = data_q;
    end

endmodule

// File: rtl/eprom_erase_seq.sv
module eprom_erase_seq
    import eprom_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          erase_req,
    output logic          busy,
    output logic          clr_we,
    output logic [AW-1:0] clr_addr
);

    localparam logic [AW-1:0] LAST = {AW{1'b1}};

    erase_st_e state, state_nx;
    logic [AW-1:0] idx_q;

    // state register: reset lands in the sweep so the array starts blank
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= E_SWEEP;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            E_IDLE:  if (erase_req) state_nx = E_SWEEP;        // start
            E_SWEEP: if (idx_q == LAST) state_nx = E_IDLE;     // done
            default: state_nx = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx_q <= '0;
        else if (state == E_SWEEP)
            idx_q <= idx_q + 1'b1;
        else
            idx_q <= '0;
    end

    // outputs
    always_comb begin
        busy     = (state == E_SWEEP);
        clr_we   = (state == E_SWEEP);
        clr_addr = idx_q;
    end

endmodule

// File: rtl/eprom_array.sv
module eprom_array
    import eprom_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_we,
    input  logic [AW-1:0] clr_addr,
    input  logic          prog_we,
    input  logic [AW-1:0] prog_addr,
    input  logic [7:0]    prog_data,
    input  logic          rd_en,
    input  logic          id_sel,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    data_out,
    output logic          data_oe
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    // single write port: the erase sweep wins over a program commit
    always_ff @(posedge clk) begin
        if (clr_we)
            cells[clr_addr] <= BLANK;
        else if (prog_we)
            cells[prog_addr] <= cells[prog_addr] & prog_data;
    end

    // registered bus stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_oe  <= 1'b0;
            data_out <= '0;
        end else begin
            data_oe <= rd_en;
            if (!rd_en)
                data_out <= '0;
            else if (id_sel)
                data_out <= rd_addr[0] ? DEV_ID : MFG_ID;
            else
                data_out <= cells[rd_addr];
        end
    end

endmodule

// File: rtl/eprom_model.sv
module eprom_model
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ARR_AW = 6,
    parameter int PW_MIN = 95,
    parameter int PW_MAX = 105
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hv,
    input  logic              vcc_prog,
    input  logic              id_hv,
    input  logic [7:0]        data_in,
    input  logic              erase_req,
    output logic [7:0]        data_out,
    output logic              data_oe,
    output logic              erase_busy
);

    logic [ARR_AW-1:0] cell_addr;
    logic              drive, id_sel, prog_ok;
    logic              prog_we, clr_we;
    logic [ARR_AW-1:0] prog_addr, clr_addr;
    logic [7:0]        prog_data;

    assign cell_addr = addr[ARR_AW-1:0];

    eprom_mode_dec u_dec (
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .vpp_hv   (vpp_hv),
        .vcc_prog (vcc_prog),
        .id_hv    (id_hv),
        .busy     (erase_busy),
        .drive    (drive),
        .id_sel   (id_sel),
        .prog_ok  (prog_ok)
    );

    eprom_pulse_fsm #(
        .AW     (ARR_AW),
        .PW_MIN (PW_MIN),
        .PW_MAX (PW_MAX)
    ) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .prog_ok (prog_ok),
        .ce_n    (ce_n),
        .addr_in (cell_addr),
        .data_in (data_in),
        .wr_en   (prog_we),
        .wr_addr (prog_addr),
        .wr_data (prog_data)
    );

    eprom_erase_seq #(.AW(ARR_AW)) u_erase (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase_req (erase_req),
        .busy      (erase_busy),
        .clr_we    (clr_we),
        .clr_addr  (clr_addr)
    );

    eprom_array #(.AW(ARR_AW)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_we    (clr_we),
        .clr_addr  (clr_addr),
        .prog_we   (prog_we),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .rd_en     (drive),
        .id_sel    (id_sel),
        .rd_addr   (cell_addr),
        .data_out  (data_out),
        .data_oe   (data_oe)
    );

endmodule

// File: rtl/eprom_model_chk.sv
module eprom_model_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       oe_n,
    input logic       vpp_hv,
    input logic       vcc_prog,
    input logic       id_hv,
    input logic       addr0,
    input logic       erase_req,
    input logic [7:0] data_out,
    input logic       data_oe,
    input logic       erase_busy,
    input logic       prog_we
);

    // R2
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !vpp_hv && !erase_busy) |=> data_oe);

    // R3
    standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && !vpp_hv) |=> !data_oe);

    // R4
    out_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n && !vpp_hv) |=> !data_oe);

    // R8
    prog_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vpp_hv |=> !data_oe);

    // R5
    commit_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |-> ($past(ce_n) && $past(vpp_hv) && $past(vcc_prog)));

    // R7
    commit_low_before_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |-> !$past(ce_n, 2));

    // R10
    mfg_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !vpp_hv && id_hv && !erase_busy && !addr0)
        |=> (data_out == 8'h8F));

    // R10
    dev_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !vpp_hv && id_hv && !erase_busy && addr0)
        |=> (data_out == 8'h85));

    // R11
    erase_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && !erase_busy) |=> erase_busy);

    // R11
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_busy |=> !data_oe);

    // R11
    busy_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(erase_busy) |-> !prog_we);

endmodule

bind eprom_model eprom_model_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .vpp_hv     (vpp_hv),
    .vcc_prog   (vcc_prog),
    .id_hv      (id_hv),
    .addr0      (addr[0]),
    .erase_req  (erase_req),
    .data_out   (data_out),
    .data_oe    (data_oe),
    .erase_busy (erase_busy),
    .prog_we    (prog_we)
);

// File: tb/tb_eprom_model.sv
`timescale 1ns/1ps
module tb_eprom_model;

    localparam int ADDR_W = 16;
    localparam int ARR_AW = 6;
    localparam int DEPTH  = 1 << ARR_AW;
    localparam int PW_MIN = 95;
    localparam int PW_MAX = 105;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] addr;
    logic              ce_n, oe_n, vpp_hv, vcc_prog, id_hv, erase_req;
    logic [7:0]        data_in;
    logic [7:0]        data_out;
    logic              data_oe, erase_busy;

    int nchk = 0;
    int nfail = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    eprom_model #(
        .ADDR_W(ADDR_W), .ARR_AW(ARR_AW), .PW_MIN(PW_MIN), .PW_MAX(PW_MAX)
    ) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
        .vpp_hv(vpp_hv), .vcc_prog(vcc_prog), .id_hv(id_hv),
        .data_in(data_in), .erase_req(erase_req),
        .data_out(data_out), .data_oe(data_oe), .erase_busy(erase_busy)
    );

    // ---------------- behavioural reference ----------------
    logic [7:0] ref_mem [DEPTH];
    int  busy_left;
    int  phase;      // 0 idle, 1 armed, 2 in pulse, 3 commit, 4 blocked
    int  low_len;
    int  lat_a;
    logic [7:0] lat_d;
    logic exp_oe = 1'b0, exp_busy = 1'b1;
    logic [7:0] exp_do = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            busy_left = DEPTH;
            phase = 0;
            low_len = 0;
            exp_oe = 1'b0;
            exp_busy = 1'b1;
            foreach (ref_mem[i]) ref_mem[i] = 8'hFF;
        end else begin
            bit was_busy, can_prog, nxt_oe;
            logic [7:0] nxt_do;
            was_busy = (busy_left > 0);
            nxt_oe = !was_busy && !ce_n && !oe_n && !vpp_hv;
            nxt_do = id_hv ? (addr[0] ? 8'h85 : 8'h8F) : ref_mem[addr % DEPTH];
            can_prog = vpp_hv && vcc_prog && !was_busy;
            case (phase)
                0: if (can_prog) phase = ce_n ? 1 : 4;
                1: if (!can_prog) phase = 0;
                   else if (!ce_n) begin
                       phase = 2; low_len = 1; lat_a = addr % DEPTH; lat_d = data_in;
                   end
                2: if (!can_prog) phase = 0;
                   else if (!ce_n) begin
                       if (low_len >= PW_MAX) phase = 4; else low_len++;
                   end else phase = (low_len >= PW_MIN) ? 3 : 1;
                3: begin ref_mem[lat_a] = ref_mem[lat_a] & lat_d; phase = 1; end
                default: if (!can_prog) phase = 0; else if (ce_n) phase = 1;
            endcase
            if (busy_left > 0) busy_left--;
            else if (erase_req) begin
                busy_left = DEPTH;
                foreach (ref_mem[i]) ref_mem[i] = 8'hFF;
            end
            exp_oe = nxt_oe;
            exp_do = nxt_do;
            exp_busy = (busy_left > 0);
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            nchk++;
            if (erase_busy !== exp_busy || data_oe !== exp_oe ||
                (exp_oe && data_out !== exp_do)) begin
                nfail++;
                $display("FAIL %s cycle compare: busy=%b oe=%b data=%h expected busy=%b oe=%b data=%h",
                         cur_req, erase_busy, data_oe, data_out, exp_busy, exp_oe, exp_do);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk_read(input logic [ADDR_W-1:0] a, input bit idm,
                            input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; id_hv = idm;
        @(negedge clk);
        nchk++;
        if (data_oe !== 1'b1 || data_out !== exp) begin
            nfail++;
            $display("FAIL %s read %h: oe=%b data=%h expected oe=1 data=%h",
                     tag, a, data_oe, data_out, exp);
        end
        ce_n = 1'b1; oe_n = 1'b1; id_hv = 1'b0;
    endtask

    task automatic chk_off(input bit c, input bit o, input bit v, input string tag);
        @(negedge clk);
        ce_n = c; oe_n = o; vpp_hv = v;
        @(negedge clk);
        nchk++;
        if (data_oe !== 1'b0) begin
            nfail++;
            $display("FAIL %s bus release: oe=%b expected 0", tag, data_oe);
        end
        ce_n = 1'b1; oe_n = 1'b1; vpp_hv = 1'b0;
    endtask

    task automatic prog_on(input bit vcc);
        @(negedge clk);
        oe_n = 1'b1; vpp_hv = 1'b1; vcc_prog = vcc;
        repeat (2) @(negedge clk);
    endtask

    task automatic prog_off();
        @(negedge clk);
        ce_n = 1'b1; vpp_hv = 1'b0; vcc_prog = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic strobe(input logic [ADDR_W-1:0] a, input logic [7:0] d, input int n);
        @(negedge clk);
        addr = a; data_in = d; ce_n = 1'b0;
        repeat (n) @(negedge clk);
        ce_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (erase_busy !== 1'b0) @(negedge clk);
        @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #500000;
        nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    // ---------------- sequence ----------------
    initial begin
        rst_n = 1'b0; addr = '0; ce_n = 1'b1; oe_n = 1'b1; vpp_hv = 1'b0;
        vcc_prog = 1'b0; id_hv = 1'b0; data_in = '0; erase_req = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        nchk++;
        if (erase_busy !== 1'b1 || data_oe !== 1'b0) begin
            nfail++;
            $display("FAIL R1 reset: busy=%b oe=%b expected busy=1 oe=0", erase_busy, data_oe);
        end
        rst_n = 1'b1;
        repeat (DEPTH - 1) @(negedge clk);
        // R1: still busy on the last sweep cycle, then released
        nchk++;
        if (erase_busy !== 1'b1) begin
            nfail++;
            $display("FAIL R1 sweep length: busy=%b expected 1", erase_busy);
        end
        @(negedge clk);
        nchk++;
        if (erase_busy !== 1'b0) begin
            nfail++;
            $display("FAIL R1 sweep end: busy=%b expected 0", erase_busy);
        end
        chk_read(16'h0000, 1'b0, 8'hFF, "R1");
        chk_read(16'h003F, 1'b0, 8'hFF, "R1");

        cur_req = "R5";
        prog_on(1'b1);
        strobe(16'h0003, 8'hA5, 100);
        prog_off();
        chk_read(16'h0003, 1'b0, 8'hA5, "R5");

        cur_req = "R6";
        prog_on(1'b1);
        strobe(16'h0003, 8'h0F, PW_MIN);
        strobe(16'h0003, 8'hFF, 100);
        prog_off();
        chk_read(16'h0003, 1'b0, 8'h05, "R6");

        cur_req = "R7";
        prog_on(1'b1);
        strobe(16'h0005, 8'h00, PW_MIN - 1);
        strobe(16'h0005, 8'h00, PW_MAX + 1);
        strobe(16'h0006, 8'h3C, PW_MAX);
        prog_off();
        chk_read(16'h0005, 1'b0, 8'hFF, "R7");
        chk_read(16'h0006, 1'b0, 8'h3C, "R7");

        // R7: strobe already low when programming conditions arrive
        @(negedge clk);
        addr = 16'h0007; data_in = 8'h11; ce_n = 1'b0;
        prog_on(1'b1);
        repeat (100) @(negedge clk);
        ce_n = 1'b1;
        repeat (3) @(negedge clk);
        prog_off();
        chk_read(16'h0007, 1'b0, 8'hFF, "R7");
        prog_on(1'b1);
        strobe(16'h0007, 8'h11, 100);
        prog_off();
        chk_read(16'h0007, 1'b0, 8'h11, "R7");

        cur_req = "R8";
        prog_on(1'b0);
        strobe(16'h0008, 8'h00, 100);
        prog_off();
        chk_read(16'h0008, 1'b0, 8'hFF, "R8");
        prog_on(1'b1);
        @(negedge clk);
        oe_n = 1'b0;
        repeat (110) @(negedge clk);
        oe_n = 1'b1;
        prog_off();
        chk_read(16'h0008, 1'b0, 8'hFF, "R8");
        chk_off(1'b0, 1'b0, 1'b1, "R8");

        cur_req = "R2";
        chk_read(16'hFF83, 1'b0, 8'h05, "R2");
        chk_read(16'h1246, 1'b0, 8'h3C, "R2");

        cur_req = "R9";
        @(negedge clk);
        vcc_prog = 1'b1;
        chk_read(16'h0006, 1'b0, 8'h3C, "R9");
        @(negedge clk);
        vcc_prog = 1'b0;

        cur_req = "R10";
        chk_read(16'h0000, 1'b1, 8'h8F, "R10");
        chk_read(16'h0001, 1'b1, 8'h85, "R10");
        chk_read(16'h0202, 1'b1, 8'h8F, "R10");

        cur_req = "R3";
        chk_off(1'b1, 1'b0, 1'b0, "R3");
        cur_req = "R4";
        chk_off(1'b0, 1'b1, 1'b0, "R4");

        cur_req = "R11";
        @(negedge clk);
        erase_req = 1'b1;
        @(negedge clk);
        erase_req = 1'b0;
        nchk++;
        if (erase_busy !== 1'b1) begin
            nfail++;
            $display("FAIL R11 erase start: busy=%b expected 1", erase_busy);
        end
        chk_off(1'b0, 1'b0, 1'b0, "R11");
        prog_on(1'b1);
        strobe(16'h0009, 8'h00, 100);
        prog_off();
        wait_idle();
        chk_read(16'h0003, 1'b0, 8'hFF, "R11");
        chk_read(16'h0006, 1'b0, 8'hFF, "R11");
        chk_read(16'h0009, 1'b0, 8'hFF, "R11");

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule